// File: doc/BRIEF.md
# Eight-to-One Integrator-Comb Decimator with Power-of-Two Scaling

This block lowers the sample rate of one real signed stream by exactly eight. Three running-sum stages operate on every accepted input word; once every eighth accepted word, three first-difference stages run on the last running sum. The result is a three-fold boxcar-of-eight filter whose DC gain is 512. That gain is removed by discarding low-order bits, and the scaled value is presented as an 18-bit word. A complex stream needs two instances, one for each of I and Q.

The input is a 16-bit two's-complement word with 15 fractional bits. The output is an 18-bit two's-complement word with 16 fractional bits. Both ends use a valid/ready handshake: a word moves when valid and ready are both high at a rising clock edge. The output word is held, together with its valid, until the consumer takes it. Back-pressure reaches the input only when it must. The input stalls only while an untaken output word is pending and the next accepted input would complete a new group of eight. The other seven input words of a group keep flowing while the output is blocked.

Top module: `cic_decim8`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `out_valid` is 0 and `in_ready` is 1. Reset clears every running sum, every difference delay and the group counter, so the first output after reset depends only on inputs accepted after reset.
- R2: Exactly one output word is produced for each group of eight accepted input words. `out_valid` is high in the cycle directly after the clock edge that accepts the eighth word of a group. No other edge raises `out_valid` or loads a new word.
- R3: Number the accepted inputs x[0], x[1] and so on. Let n be the index of the eighth word of a group. The output code is floor(S/256), where S is the sum of h[k]·x[n−k] for k from 0 to 21. The taps h are those of (1+z⁻¹+…+z⁻⁷)³, and any x with a negative index counts as 0.
- R4: A constant input code c, held long enough to fill the filter, gives a steady output code of exactly 2c. The real value is therefore preserved.
- R5: The discarded low-order bits are rounded toward minus infinity. A single input code of −1 followed by zeros gives the output codes −1, −1, 0. A single +1 gives 0, 0, 0.
- R6: The running sums wrap modulo 2^25 without saturating. Full-scale input held for thousands of samples still gives −65536 for input −32768 and 65534 for input 32767.
- R7: A cycle with `in_valid` low changes no state. Idle cycles placed anywhere between input words leave every output value unchanged.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged.
- R9: While an output word is pending and not being taken, the eighth word of the next group is refused (`in_ready` low). It is accepted in the first cycle in which `out_ready` is high.
- R10: `in_ready` is low only in the situation of R9. In particular, the first seven words of a group are each accepted in a single cycle while the output is blocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take the offered word |
| in_data | input | IN_W (16) | Input sample, signed, 15 fractional bits |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | OUT_W (18) | Decimated sample, signed, 16 fractional bits |

## Verification
The bound checker keeps its own count of accepted words. On every cycle it checks the handshake rules: the reset state, the output strobe following the eighth accepted word and no other, the output staying fixed while it is blocked, and the input stalling only on the eighth word of a blocked group. The arithmetic cannot be seen by a property. The impulse, DC, full-scale wrap and gapped-stream scenarios show the filter taps, the gain of 512, floor rounding and wrap-around against a tap model computed in the bench. The stall scenario shows that the seven non-final words still flow at full rate while the output is held.

// File: rtl/cic_decim_pkg.sv
package cic_decim_pkg;
  localparam int DEF_IN_W      = 16;
  localparam int DEF_STAGES    = 3;
  localparam int DEF_RATE_LOG2 = 3;
  localparam int DEF_OUT_W     = 18;

  // Full-precision width: input width plus the bit growth of all stages.
  function automatic int acc_width(input int in_w, input int stages, input int rate_log2);
    return in_w + stages * rate_log2;
  endfunction
endpackage

// File: rtl/cic_phase_ctrl.sv
module cic_phase_ctrl #(
  parameter int RATE_LOG2 = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic out_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic fire,
  output logic group_end
);
  logic [RATE_LOG2-1:0] phase_q;

  assign group_end = &phase_q;
  // Only the word that closes a group needs a free output slot.
  assign in_ready  = !(group_end && out_valid && !out_ready);
  assign fire      = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst)       phase_q <= '0;
    else if (fire) phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/cic_integrator_chain.sv
module cic_integrator_chain #(
  parameter int IN_W   = 16,
  parameter int ACC_W  = 25,
  parameter int STAGES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [IN_W-1:0]  din,
  output logic [ACC_W-1:0] dout
);
  logic [ACC_W-1:0] acc_q [STAGES];
  logic [ACC_W-1:0] acc_d [STAGES];
  logic [ACC_W-1:0] din_ext;

  assign din_ext = {{(ACC_W-IN_W){din[IN_W-1]}}, din};

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_head
      assign acc_d[s] = acc_q[s] + din_ext;
    end else begin : g_tail
      assign acc_d[s] = acc_q[s] + acc_d[s-1];
    end
    // Modular addition: wrap-around is intended and cancels in the combs.
    always_ff @(posedge clk) begin
      if (rst)     acc_q[s] <= '0;
      else if (en) acc_q[s] <= acc_d[s];
    end
  end

  assign dout = acc_d[STAGES-1];
endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
  parameter int ACC_W  = 25,
  parameter int STAGES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [ACC_W-1:0] din,
  output logic [ACC_W-1:0] dout
);
  logic [ACC_W-1:0] stg_in [STAGES];
  logic [ACC_W-1:0] diff   [STAGES];
  logic [ACC_W-1:0] dly_q  [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_head
      assign stg_in[s] = din;
    end else begin : g_tail
      assign stg_in[s] = diff[s-1];
    end
    assign diff[s] = stg_in[s] - dly_q[s];
    always_ff @(posedge clk) begin
      if (rst)     dly_q[s] <= '0;
      else if (en) dly_q[s] <= stg_in[s];
    end
  end

  assign dout = diff[STAGES-1];
endmodule

// File: rtl/cic_out_stage.sv
module cic_out_stage #(
  parameter int ACC_W = 25,
  parameter int OUT_W = 18,
  parameter int DROP  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [ACC_W-1:0] full,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  logic signed [ACC_W-1:0] scaled;

  // Arithmetic shift floors; the gain removal itself is a binary-point move.
  assign scaled = $signed(full) >>> DROP;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= scaled[OUT_W-1:0];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cic_decim8.sv
module cic_decim8
  import cic_decim_pkg::*;
#(
  parameter int IN_W      = DEF_IN_W,
  parameter int STAGES    = DEF_STAGES,
  parameter int RATE_LOG2 = DEF_RATE_LOG2,
  parameter int OUT_W     = DEF_OUT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);
  localparam int ACC_W = acc_width(IN_W, STAGES, RATE_LOG2);
  localparam int DROP  = ACC_W - OUT_W + 1;

  logic             fire;
  logic             group_end;
  logic             comb_en;
  logic [ACC_W-1:0] integ_out;
  logic [ACC_W-1:0] comb_out;

  assign comb_en = fire && group_end;

  cic_phase_ctrl #(.RATE_LOG2(RATE_LOG2)) phase_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
    .out_ready(out_ready), .in_ready(in_ready), .fire(fire), .group_end(group_end)
  );

  cic_integrator_chain #(.IN_W(IN_W), .ACC_W(ACC_W), .STAGES(STAGES)) integ_i (
    .clk(clk), .rst(rst), .en(fire), .din(in_data), .dout(integ_out)
  );

  cic_comb_chain #(.ACC_W(ACC_W), .STAGES(STAGES)) comb_i (
    .clk(clk), .rst(rst), .en(comb_en), .din(integ_out), .dout(comb_out)
  );

  cic_out_stage #(.ACC_W(ACC_W), .OUT_W(OUT_W), .DROP(DROP)) out_i (
    .clk(clk), .rst(rst), .load(comb_en), .full(comb_out), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/cic_decim8_chk.sv
module cic_decim8_chk #(
  parameter int RATE_LOG2 = 3,
  parameter int OUT_W     = 18
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data
);
  logic [RATE_LOG2-1:0] seen_q;
  logic                 take;
  logic                 closing;

  assign take    = in_valid && in_ready;
  assign closing = &seen_q;

  always_ff @(posedge clk) begin
    if (rst)       seen_q <= '0;
    else if (take) seen_q <= seen_q + 1'b1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && in_ready)); // R1
  AST_STROBE_ON_EIGHTH: assert property (@(posedge clk) disable iff (rst)
    (take && closing) |=> out_valid); // R2
  AST_NO_EXTRA_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!(take && closing) && (!out_valid || out_ready)) |=> !out_valid); // R2
  AST_OUTPUT_HELD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8
  AST_BLOCK_CLOSING_WORD: assert property (@(posedge clk) disable iff (rst)
    (closing && out_valid && !out_ready) |-> !in_ready); // R9
  AST_READY_OTHERWISE: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (closing && out_valid && !out_ready)); // R10
endmodule

bind cic_decim8 cic_decim8_chk #(.RATE_LOG2(RATE_LOG2), .OUT_W(OUT_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/cic_decim8_tb_top.sv
module cic_decim8_tb_top;
  localparam int IN_W = 16;
  localparam int OUT_W = 18;
  localparam int TAPS = 22;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [IN_W-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [OUT_W-1:0] out_data;

  always #2 clk = ~clk;

  cic_decim8 dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  string cur_req = "R3";
  longint h [TAPS];
  int hist [$];
  longint out_log [$];
  longint exp_val = 0;
  bit exp_pending = 0;
  bit prev_ov = 0;
  bit prev_or = 0;
  logic [OUT_W-1:0] prev_od = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Taps of three cascaded length-8 boxcars.
  task automatic build_taps();
    longint t [TAPS];
    for (int i = 0; i < TAPS; i++) h[i] = (i < 8) ? 1 : 0;
    for (int r = 0; r < 2; r++) begin
      for (int n = 0; n < TAPS; n++) begin
        t[n] = 0;
        for (int j = 0; j < 8; j++) if (n - j >= 0) t[n] += h[n-j];
      end
      for (int n = 0; n < TAPS; n++) h[n] = t[n];
    end
  endtask

  function automatic longint model();
    longint s = 0;
    int n = hist.size() - 1;
    for (int k = 0; k < TAPS; k++) if (n - k >= 0) s += h[k] * hist[n-k];
    return s >>> 8;
  endfunction

  // Monitor: samples 1 ns after the falling edge, i.e. the values the next rising edge sees.
  always begin
    @(negedge clk);
    #1;
    if (rst) begin
      hist.delete();
      exp_pending = 0;
      prev_ov = 0;
    end else begin
      if (exp_pending) begin
        check(out_valid === 1'b1, "R2", "valid after eighth word", longint'(out_valid), 1);
        check($signed(out_data) == exp_val, cur_req, "decimated value", $signed(out_data), exp_val);
        exp_pending = 0;
      end else if (out_valid && !prev_ov) begin
        check(1'b0, "R2", "strobe without eighth word", 1, 0);
      end
      if (prev_ov && !prev_or)
        check(out_valid === 1'b1 && out_data === prev_od, "R8", "held output",
              $signed(out_data), $signed(prev_od));
      if (out_valid && out_ready) out_log.push_back($signed(out_data));
      if (in_valid && in_ready) begin
        hist.push_back(int'($signed(in_data)));
        if (hist.size() % 8 == 0) begin
          exp_val = model();
          exp_pending = 1;
        end
      end
      prev_ov = out_valid;
      prev_or = out_ready;
      prev_od = out_data;
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid === 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
    @(negedge clk);
    rst = 1'b0;
    out_log.delete();
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int x);
    bit acc;
    in_valid = 1'b1;
    in_data = x[IN_W-1:0];
    do begin
      #1;
      acc = in_ready;
      @(negedge clk);
    end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    cur_req = "R1";
    do_reset();
    #1;
    check(out_valid === 1'b0, "R1", "out_valid after release", longint'(out_valid), 0);
    check(in_ready === 1'b1, "R1", "in_ready after release", longint'(in_ready), 1);
    @(negedge clk);
    for (int i = 0; i < 21; i++) send(1000 * i - 9000);
    idle(2);
  endtask

  task automatic t_impulse(input int amp);
    longint e0 = (amp < 0) ? -1 : 0;
    cur_req = "R5";
    do_reset();
    send(amp);
    repeat (23) send(0);
    idle(3);
    check(out_log.size() == 3, "R2", "impulse output count", out_log.size(), 3);
    if (out_log.size() == 3) begin
      check(out_log[0] == e0, "R5", "impulse out0", out_log[0], e0);
      check(out_log[1] == e0, "R5", "impulse out1", out_log[1], e0);
      check(out_log[2] == 0, "R1", "impulse out2 clean history", out_log[2], 0);
    end
  endtask

  task automatic t_dc(input int val, input int count, input string req);
    longint want = 2 * val;
    bit all_ok = 1;
    cur_req = req;
    do_reset();
    repeat (count) send(val);
    idle(3);
    check(out_log.size() == count / 8, "R2", "dc output count", out_log.size(), count / 8);
    for (int i = 3; i < out_log.size(); i++) if (out_log[i] != want) all_ok = 0;
    check(all_ok, req, "dc steady outputs",
          (out_log.size() > 0) ? out_log[out_log.size()-1] : 0, want);
  endtask

  task automatic t_gaps();
    logic [15:0] lfsr = 16'hACE1;
    cur_req = "R7";
    do_reset();
    for (int i = 0; i < 240; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(int'($signed(lfsr)));
      idle(int'(lfsr[1:0]));
    end
    idle(3);
    check(out_log.size() == 30, "R2", "gapped output count", out_log.size(), 30);
  endtask

  task automatic t_backpressure();
    time t0;
    cur_req = "R9";
    do_reset();
    out_ready = 1'b0;
    for (int i = 0; i < 8; i++) send(4000 + 300 * i);
    idle(1);
    t0 = $time;
    for (int i = 0; i < 7; i++) send(-2000 * i);
    check(($time - t0) == 28, "R10", "seven words while blocked take 7 cycles",
          longint'($time - t0), 28);
    in_valid = 1'b1;
    in_data = 16'sd12345;
    for (int i = 0; i < 5; i++) begin
      #1;
      check(in_ready === 1'b0, "R9", "closing word refused", longint'(in_ready), 0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    #1;
    check(in_ready === 1'b1, "R9", "closing word taken on release", longint'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    idle(3);
    check(out_log.size() == 2, "R9", "outputs after stall", out_log.size(), 2);
  endtask

  initial begin
    build_taps();
    @(negedge clk);
    t_reset();
    t_impulse(1);
    t_impulse(-1);
    t_dc(1000, 64, "R4");
    t_dc(-3, 48, "R4");
    t_dc(-32768, 2000, "R6");
    t_dc(32767, 2000, "R6");
    t_gaps();
    t_backpressure();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule